// File: doc/BRIEF.md
# Two-Cell Pack Protection Controller

This block is the digital decision core of a protector for a pack of two series cells. Analog comparators outside the block turn each cell voltage into flags: above the over-charge limit, above the auxiliary (hard) over-charge limit, below the charge-release level, below the over-discharge limit, and at or above the discharge-release level. Two more flags describe the load node. One says the load node sits at or above overcurrent level 1. The other says a charger is present because the supply-to-load-node voltage reaches level 2.

From these flags the controller chooses the pack state. It drives the charge-FET enable, the discharge-FET enable, the load-node resistor select (pull-down to ground or pull-up to the supply) and a power-down flag. Every flag first passes through a two-flop synchroniser. Faults that need a minimum duration are qualified by counters whose lengths are parameters. The cell count is also a parameter and defaults to two.

States and outputs (chg_fet_en, dis_fet_en, pullup_sel, pwr_down): normal 1,1,0,0; overcurrent 0,0,0,0; over-charge 0,1,0,0; power-down 1,0,1,1; discharge recovery 1,0,1,0.

Top module: `bp_ctrl`

## Requirements
- R1: After synchronous reset, and in the normal state, the outputs are chg_fet_en=1, dis_fet_en=1, pullup_sel=0, pwr_down=0.
- R2: In normal, load_oc1 held high for OC_TICKS consecutive synchronised cycles enters overcurrent: chg_fet_en=0, dis_fet_en=0, pullup_sel=0, pwr_down=0.
- R3: Overcurrent returns to normal once load_oc1 is low.
- R4: In normal, any bit of cell_ovc held high for OVC_TICKS consecutive synchronised cycles enters over-charge: only chg_fet_en drops.
- R5: Any bit of cell_ovc_aux enters over-charge at once, without waiting for the delay.
- R6: Over-charge returns to normal when every cell that caused the entry reports cell_below_rel=1. Cells that were not involved have no effect.
- R7: Over-charge also returns to normal when load_oc1 goes high, because discharge current is flowing through the charge FET's body diode.
- R8: In normal, any bit of cell_ovd held high for OVD_TICKS consecutive synchronised cycles enters power-down: dis_fet_en=0, pullup_sel=1, pwr_down=1, chg_fet_en=1.
- R9: Power-down is left only when chg_det2 is high. The controller then holds discharge recovery (pwr_down=0, dis_fet_en=0, pullup_sel=1).
- R10: Discharge recovery returns to normal only once every bit of cell_above_dur is high.
- R11: A delay counter restarts from zero when its condition drops for even one cycle, so the condition must then hold for the full delay again.
- R12: When several fault entries qualify on the same edge, overcurrent wins over over-discharge, and over-discharge wins over over-charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cell_ovc | input | NCELL | Cell above over-charge limit |
| cell_ovc_aux | input | NCELL | Cell above auxiliary over-charge limit |
| cell_below_rel | input | NCELL | Cell below charge-release level |
| cell_ovd | input | NCELL | Cell below over-discharge limit |
| cell_above_dur | input | NCELL | Cell at or above discharge-release level |
| load_oc1 | input | 1 | Load node at or above overcurrent level 1 |
| chg_det2 | input | 1 | Charger present (level 2 between supply and load node) |
| chg_fet_en | output | 1 | Charge FET enable |
| dis_fet_en | output | 1 | Discharge FET enable |
| pullup_sel | output | 1 | 1: load node pulled up to supply; 0: pulled down to ground |
| pwr_down | output | 1 | Power-down flag |

## Verification
A flag that changes ahead of clock edge 1 reaches the state logic after edge 2. A release or an immediate auxiliary entry therefore shows at the outputs after edge 3. A delayed entry with a count of T shows after edge T+2. Each scenario drives inputs just after a rising edge. It checks one edge before the due edge that nothing has changed yet, and on the due edge that the change has arrived. Restart and priority cases are timed so that the competing counters terminate on the same edge.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_OVERCUR = 3'd1,
        ST_OVERCHG = 3'd2,
        ST_PWRDN   = 3'd3,
        ST_DISREC  = 3'd4
    } bp_state_e;
endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/bp_delay_timer.sv
module bp_delay_timer #(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fire
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (!fire)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R11
    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0); // R11
endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
    import bp_pkg::*;
#(
    parameter int NCELL     = 2,
    parameter int OC_TICKS  = 8,
    parameter int OVC_TICKS = 16,
    parameter int OVD_TICKS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCELL-1:0] cell_ovc,
    input  logic [NCELL-1:0] cell_ovc_aux,
    input  logic [NCELL-1:0] cell_below_rel,
    input  logic [NCELL-1:0] cell_ovd,
    input  logic [NCELL-1:0] cell_above_dur,
    input  logic             load_oc1,
    input  logic             chg_det2,
    output logic             chg_fet_en,
    output logic             dis_fet_en,
    output logic             pullup_sel,
    output logic             pwr_down
);
    localparam int SW = 5 * NCELL + 2;

    typedef struct packed {
        bp_state_e        st;
        logic [NCELL-1:0] offend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SW-1:0]    raw_flags, syn_flags;
    logic [NCELL-1:0] s_ovc, s_aux, s_below_rel, s_ovd, s_above_dur;
    logic             s_oc1, s_chg2;
    logic             in_normal;
    logic             oc_fire, ovd_fire, ovc_fire;

    assign raw_flags = {chg_det2, load_oc1, cell_above_dur, cell_ovd,
                        cell_below_rel, cell_ovc_aux, cell_ovc};

    bp_sync #(.WIDTH(SW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_flags),
        .sync_out (syn_flags)
    );

    assign {s_chg2, s_oc1, s_above_dur, s_ovd, s_below_rel, s_aux, s_ovc} = syn_flags;

    assign in_normal = (ctl_q.st == ST_NORMAL);

    bp_delay_timer #(.TICKS(OC_TICKS)) u_oc_tmr (
        .clk (clk), .rst_n (rst_n), .run (in_normal && s_oc1), .fire (oc_fire)
    );
    bp_delay_timer #(.TICKS(OVD_TICKS)) u_ovd_tmr (
        .clk (clk), .rst_n (rst_n), .run (in_normal && (|s_ovd)), .fire (ovd_fire)
    );
    bp_delay_timer #(.TICKS(OVC_TICKS)) u_ovc_tmr (
        .clk (clk), .rst_n (rst_n), .run (in_normal && (|s_ovc)), .fire (ovc_fire)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_NORMAL: begin
                if (oc_fire) begin
                    ctl_d.st = ST_OVERCUR;
                end else if (ovd_fire) begin
                    ctl_d.st = ST_PWRDN;
                end else if (ovc_fire || (|s_aux)) begin
                    ctl_d.st     = ST_OVERCHG;
                    ctl_d.offend = s_ovc | s_aux;
                end
            end
            ST_OVERCUR: begin
                if (!s_oc1) ctl_d.st = ST_NORMAL;
            end
            ST_OVERCHG: begin
                if (s_oc1 || ((ctl_q.offend & ~s_below_rel) == '0)) begin
                    ctl_d.st     = ST_NORMAL;
                    ctl_d.offend = '0;
                end
            end
            ST_PWRDN: begin
                if (s_chg2) ctl_d.st = ST_DISREC;
            end
            ST_DISREC: begin
                if (&s_above_dur) ctl_d.st = ST_NORMAL;
            end
            default: begin
                ctl_d.st     = ST_NORMAL;
                ctl_d.offend = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_NORMAL;
            ctl_q.offend <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        chg_fet_en = 1'b1;
        dis_fet_en = 1'b1;
        pullup_sel = 1'b0;
        pwr_down   = 1'b0;
        unique case (ctl_q.st)
            ST_OVERCUR: begin
                chg_fet_en = 1'b0;
                dis_fet_en = 1'b0;
            end
            ST_OVERCHG: chg_fet_en = 1'b0;
            ST_PWRDN: begin
                dis_fet_en = 1'b0;
                pullup_sel = 1'b1;
                pwr_down   = 1'b1;
            end
            ST_DISREC: begin
                dis_fet_en = 1'b0;
                pullup_sel = 1'b1;
            end
            default: ;
        endcase
    end

    AST_NORMAL_LEFT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.st) == ST_NORMAL && ctl_q.st != ST_NORMAL)
        |-> $past(oc_fire || ovd_fire || ovc_fire || (|s_aux))); // R2
    AST_OC_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.st) == ST_OVERCUR && ctl_q.st == ST_NORMAL) |-> !$past(s_oc1)); // R3
    AST_OC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_normal && oc_fire) |=> !dis_fet_en && !chg_fet_en && !pullup_sel); // R12
    AST_PDN_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $past(ovd_fire) && !$past(oc_fire)); // R8
    AST_PDN_NEEDS_CHARGER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> $past(s_chg2)); // R9
    AST_RECOVERY_NEEDS_ALL_CELLS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.st) == ST_DISREC && ctl_q.st == ST_NORMAL) |-> $past(&s_above_dur)); // R10
    AST_OVC_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.st) == ST_OVERCHG && ctl_q.st == ST_NORMAL)
        |-> $past(s_oc1 || ((ctl_q.offend & ~s_below_rel) == '0))); // R6
endmodule

// File: tb/tb_bp_ctrl.sv
module tb_bp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NC    = 2;
    localparam int T_OC  = 8;
    localparam int T_OVC = 16;
    localparam int T_OVD = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NC-1:0] cell_ovc, cell_ovc_aux, cell_below_rel, cell_ovd, cell_above_dur;
    logic          load_oc1, chg_det2;
    logic          chg_fet_en, dis_fet_en, pullup_sel, pwr_down;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_ctrl #(.NCELL(NC), .OC_TICKS(T_OC), .OVC_TICKS(T_OVC), .OVD_TICKS(T_OVD)) dut (
        .clk (clk), .rst_n (rst_n),
        .cell_ovc (cell_ovc), .cell_ovc_aux (cell_ovc_aux),
        .cell_below_rel (cell_below_rel), .cell_ovd (cell_ovd),
        .cell_above_dur (cell_above_dur), .load_oc1 (load_oc1), .chg_det2 (chg_det2),
        .chg_fet_en (chg_fet_en), .dis_fet_en (dis_fet_en),
        .pullup_sel (pullup_sel), .pwr_down (pwr_down)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {chg_fet_en, dis_fet_en, pullup_sel, pwr_down};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs chg,dis,pu,pdn = %b expected %b", req, act, exp);
        end
    endtask

    localparam logic [3:0] O_NORM = 4'b1100;
    localparam logic [3:0] O_OC   = 4'b0000;
    localparam logic [3:0] O_OVC  = 4'b0100;
    localparam logic [3:0] O_PDN  = 4'b1011;
    localparam logic [3:0] O_REC  = 4'b1010;

    task automatic idle_inputs();
        cell_ovc = '0; cell_ovc_aux = '0; cell_below_rel = '1;
        cell_ovd = '0; cell_above_dur = '1; load_oc1 = 1'b0; chg_det2 = 1'b0;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 1'b0;
        tick(3);
        expect_out("R1 in reset", O_NORM);
        rst_n = 1'b1;
        tick(4);
        expect_out("R1 idle normal", O_NORM);
    endtask

    task automatic t_overcurrent();
        load_oc1 = 1'b1;
        tick(T_OC + 1);
        expect_out("R2 before delay", O_NORM);
        tick(1);
        expect_out("R2 after delay", O_OC);
        load_oc1 = 1'b0;
        tick(2);
        expect_out("R3 still held", O_OC);
        tick(1);
        expect_out("R3 released", O_NORM);
    endtask

    task automatic t_restart();
        load_oc1 = 1'b1;
        tick(T_OC - 1);
        load_oc1 = 1'b0;
        tick(1);
        load_oc1 = 1'b1;
        tick(T_OC + 1);
        expect_out("R11 restarted count", O_NORM);
        tick(1);
        expect_out("R11 full delay after break", O_OC);
        load_oc1 = 1'b0;
        tick(3);
        expect_out("R11 back to normal", O_NORM);
    endtask

    task automatic t_overcharge();
        cell_ovc[1] = 1'b1; cell_below_rel[1] = 1'b0;
        tick(T_OVC + 1);
        expect_out("R4 before delay", O_NORM);
        tick(1);
        expect_out("R4 after delay", O_OVC);
        cell_ovc[1] = 1'b0; cell_below_rel[0] = 1'b0;
        tick(5);
        expect_out("R6 offending cell not released", O_OVC);
        cell_below_rel[1] = 1'b1;
        tick(2);
        expect_out("R6 release pending", O_OVC);
        tick(1);
        expect_out("R6 released, other cell ignored", O_NORM);
        cell_below_rel[0] = 1'b1;
        tick(2);
    endtask

    task automatic t_aux();
        cell_ovc_aux[0] = 1'b1; cell_ovc[0] = 1'b1; cell_below_rel[0] = 1'b0;
        tick(2);
        expect_out("R5 before sync", O_NORM);
        tick(1);
        expect_out("R5 immediate entry", O_OVC);
        cell_ovc_aux[0] = 1'b0;
        tick(4);
        expect_out("R7 held without discharge", O_OVC);
        load_oc1 = 1'b1;
        tick(2);
        expect_out("R7 release pending", O_OVC);
        tick(1);
        expect_out("R7 released by discharge", O_NORM);
        idle_inputs();
        tick(4);
        expect_out("R7 settled normal", O_NORM);
    endtask

    task automatic t_overdischarge();
        cell_ovd[0] = 1'b1; cell_above_dur[0] = 1'b0;
        tick(T_OVD + 1);
        expect_out("R8 before delay", O_NORM);
        tick(1);
        expect_out("R8 power-down", O_PDN);
        cell_ovd[0] = 1'b0;
        tick(6);
        expect_out("R9 no charger stays down", O_PDN);
        chg_det2 = 1'b1;
        tick(2);
        expect_out("R9 charger pending", O_PDN);
        tick(1);
        expect_out("R9 recovery", O_REC);
        tick(4);
        expect_out("R10 cell not yet released", O_REC);
        cell_above_dur[0] = 1'b1;
        tick(2);
        expect_out("R10 release pending", O_REC);
        tick(1);
        expect_out("R10 back to normal", O_NORM);
        chg_det2 = 1'b0;
        tick(2);
    endtask

    task automatic t_priority();
        cell_ovd[1] = 1'b1; cell_above_dur[1] = 1'b0;
        tick(T_OVD - T_OC);
        load_oc1 = 1'b1;
        tick(T_OC + 1);
        expect_out("R12 before both fire", O_NORM);
        tick(1);
        expect_out("R12 overcurrent wins", O_OC);
        idle_inputs();
        tick(3);
        expect_out("R12 normal after release", O_NORM);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        t_reset();
        t_overcurrent();
        t_restart();
        t_overcharge();
        t_aux();
        t_overdischarge();
        t_priority();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule